// File: doc/BRIEF.md
# Dual-Clock Per-Channel Double Symbol Buffer

This block sits between a time-shared symbol producer, clocked at a multiple of the baseband rate, and a bank of per-channel consumers that each take one symbol per baseband clock. Every channel owns a memory split into two equal halves. The producer fills one half of a channel while that channel's consumer drains the other. A channel switches halves only when a full half has been written and the reader has reached the end of its current half.

On the write side, a single symbol port carries a channel number. Each channel keeps its own write position, so bursts and symbol-by-symbol interleaving across channels are both accepted. When the last location of a half is written, the write side flips a one-bit ready flag. A two-flop synchronizer carries that flag into the read clock domain. The symbols themselves cross through dual-port storage.

The read side of all channels shares one half-period counter. At each half boundary a channel either takes the newly completed half or, if none is waiting, emits a half of zeros. Once the channel has delivered data at least once, it also raises an underrun indication for that half.

Top module: `sym_pingpong_buf`

## Requirements
- R1: While rst_ni is low, rd_data_o is all zero and rd_valid_o, rd_sof_o and underrun_o are all low.
- R2: Until a channel has received its first complete half, that channel outputs zeros with rd_valid_o and underrun_o low.
- R3: A half of HALF_DEPTH symbols written to channel c becomes readable at a later half boundary. Over the following HALF_DEPTH read cycles, channel c outputs those symbols in write order with rd_valid_o high. rd_sof_o is high on the first symbol of the half and low on the rest.
- R4: Consecutive halves written to one channel go to alternate memory halves, and each is delivered intact, in the order written.
- R5: A write with wr_valid_i high goes only to the channel given by wr_ch_i. Symbols for several channels may be interleaved one by one without disturbing each other.
- R6: A cycle with wr_valid_i low writes nothing and does not advance any channel's write position, whatever wr_ch_i and wr_data_i hold.
- R7: If a channel that has delivered data before reaches a boundary with no new complete half, it outputs zeros for the whole half. During that half, rd_valid_o is low and underrun_o is high.
- R8: A channel's rd_valid_o and underrun_o change only on the cycle where rd_sof_o is high. A half that completes in the middle of a read half does not affect output until the next boundary.
- R9: rd_sof_o is high on all channels together, for one read cycle every HALF_DEPTH read cycles. Read data follows the read address by one registered cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_wr_i | input | 1 | Producer clock (multiple of the baseband rate) |
| clk_rd_i | input | 1 | Consumer clock (baseband rate) |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| wr_valid_i | input | 1 | Symbol on wr_data_i is to be stored |
| wr_ch_i | input | CH_W | Channel the symbol belongs to |
| wr_data_i | input | SYM_W | Symbol value |
| rd_data_o | output | N_CH*SYM_W | Per-channel symbol output; channel c in bits [c*SYM_W +: SYM_W] |
| rd_valid_o | output | N_CH | Channel output carries stored symbols this half |
| rd_sof_o | output | N_CH | First symbol slot of a read half |
| underrun_o | output | N_CH | Channel is outputting a zero half after an underrun |

## Verification
Two events can land in the same read half: the write side finishing a half (its ready flag arriving through the synchronizer) and the read side running an underrun half, or reading the other half. The bench completes a new half for one channel about 100 read cycles into an underrun half. It requires the zeros and underrun_o to persist unchanged to the end of that half, and the new symbols to appear only from the next rd_sof_o. It also writes two channels symbol by symbol while one of them is being read, with invalid filler cycles in between. It then checks that both channels deliver their own sequences intact.

// File: rtl/ppb_pkg.sv
`timescale 1ns/1ps
package ppb_pkg;
  function automatic int idx_bits(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/ppb_dpram.sv
`timescale 1ns/1ps
module ppb_dpram #(
  parameter int DW = 16,
  parameter int AW = 9
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i) begin
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/ppb_sync2.sv
`timescale 1ns/1ps
module ppb_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      q_o    <= 1'b0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/ppb_wr_ctrl.sv
`timescale 1ns/1ps
module ppb_wr_ctrl #(
  parameter int HALF_AW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  output logic             we_o,
  output logic [HALF_AW:0] waddr_o,
  output logic             tgl_o
);
  logic [HALF_AW-1:0] pos_q;
  logic               half_q;
  logic               tgl_q;

  assign we_o    = hit_i;
  assign waddr_o = {half_q, pos_q};
  assign tgl_o   = tgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      half_q <= 1'b0;
      tgl_q  <= 1'b0;
    end else if (hit_i) begin
      pos_q <= pos_q + 1'b1;
      // last slot of a half: hand it over
      if (&pos_q) begin
        half_q <= ~half_q;
        tgl_q  <= ~tgl_q;
      end
    end
  end
endmodule

// File: rtl/ppb_rd_ctrl.sv
`timescale 1ns/1ps
module ppb_rd_ctrl #(
  parameter int HALF_AW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tgl_sync_i,
  output logic [HALF_AW:0] raddr_o,
  output logic             valid_o,
  output logic             sof_o,
  output logic             und_o
);
  logic [HALF_AW-1:0] pos_q;
  logic cur_q, nxt_q, act_q, primed_q, seen_q, und_q;
  logic boundary, avail;

  assign boundary = &pos_q;
  assign avail    = tgl_sync_i ^ seen_q;
  assign raddr_o  = {cur_q, pos_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q    <= '0;
      cur_q    <= 1'b0;
      nxt_q    <= 1'b0;
      act_q    <= 1'b0;
      primed_q <= 1'b0;
      seen_q   <= 1'b0;
      und_q    <= 1'b0;
    end else begin
      pos_q <= pos_q + 1'b1;
      if (boundary) begin
        if (avail) begin
          act_q    <= 1'b1;
          cur_q    <= nxt_q;
          nxt_q    <= ~nxt_q;
          seen_q   <= tgl_sync_i;
          primed_q <= 1'b1;
          und_q    <= 1'b0;
        end else begin
          act_q <= 1'b0;
          und_q <= primed_q;
        end
      end
    end
  end

  // align flags with the registered memory output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sof_o   <= 1'b0;
      und_o   <= 1'b0;
    end else begin
      valid_o <= act_q;
      sof_o   <= (pos_q == '0);
      und_o   <= und_q;
    end
  end
endmodule

// File: rtl/sym_pingpong_buf.sv
`timescale 1ns/1ps
module sym_pingpong_buf #(
  parameter int N_CH       = 2,
  parameter int SYM_W      = 16,
  parameter int HALF_DEPTH = 256,
  parameter int CH_W       = ppb_pkg::idx_bits(N_CH)
) (
  input  logic                  clk_wr_i,
  input  logic                  clk_rd_i,
  input  logic                  rst_ni,
  input  logic                  wr_valid_i,
  input  logic [CH_W-1:0]       wr_ch_i,
  input  logic [SYM_W-1:0]      wr_data_i,
  output logic [N_CH*SYM_W-1:0] rd_data_o,
  output logic [N_CH-1:0]       rd_valid_o,
  output logic [N_CH-1:0]       rd_sof_o,
  output logic [N_CH-1:0]       underrun_o
);
  localparam int HALF_AW = $clog2(HALF_DEPTH);
  localparam int MEM_AW  = HALF_AW + 1;

  logic [N_CH-1:0] chan_we;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic              hit;
    logic [MEM_AW-1:0] waddr, raddr;
    logic              tgl_wr, tgl_rd;
    logic [SYM_W-1:0]  ram_q;

    assign hit = wr_valid_i && (wr_ch_i == CH_W'(g));

    ppb_wr_ctrl #(.HALF_AW(HALF_AW)) u_wr (
      .clk_i   (clk_wr_i),
      .rst_ni  (rst_ni),
      .hit_i   (hit),
      .we_o    (chan_we[g]),
      .waddr_o (waddr),
      .tgl_o   (tgl_wr)
    );

    ppb_sync2 u_sync (
      .clk_i  (clk_rd_i),
      .rst_ni (rst_ni),
      .d_i    (tgl_wr),
      .q_o    (tgl_rd)
    );

    ppb_dpram #(.DW(SYM_W), .AW(MEM_AW)) u_mem (
      .wclk_i  (clk_wr_i),
      .we_i    (chan_we[g]),
      .waddr_i (waddr),
      .wdata_i (wr_data_i),
      .rclk_i  (clk_rd_i),
      .raddr_i (raddr),
      .rdata_o (ram_q)
    );

    ppb_rd_ctrl #(.HALF_AW(HALF_AW)) u_rd (
      .clk_i      (clk_rd_i),
      .rst_ni     (rst_ni),
      .tgl_sync_i (tgl_rd),
      .raddr_o    (raddr),
      .valid_o    (rd_valid_o[g]),
      .sof_o      (rd_sof_o[g]),
      .und_o      (underrun_o[g])
    );

    assign rd_data_o[g*SYM_W +: SYM_W] = rd_valid_o[g] ? ram_q : '0;
  end
endmodule

// File: rtl/sym_pingpong_buf_chk.sv
`timescale 1ns/1ps
module sym_pingpong_buf_chk #(
  parameter int N_CH       = 2,
  parameter int SYM_W      = 16,
  parameter int HALF_DEPTH = 256
) (
  input logic                  clk_wr_i,
  input logic                  clk_rd_i,
  input logic                  rst_ni,
  input logic                  wr_valid_i,
  input logic [N_CH-1:0]       chan_we,
  input logic [N_CH*SYM_W-1:0] rd_data_o,
  input logic [N_CH-1:0]       rd_valid_o,
  input logic [N_CH-1:0]       rd_sof_o,
  input logic [N_CH-1:0]       underrun_o
);
  localparam int HALF_AW = $clog2(HALF_DEPTH);

  logic [HALF_AW-1:0] gap_q;
  logic               sof_seen_q;

  always_ff @(posedge clk_rd_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q      <= '0;
      sof_seen_q <= 1'b0;
    end else begin
      gap_q <= rd_sof_o[0] ? '0 : gap_q + 1'b1;
      if (rd_sof_o[0]) sof_seen_q <= 1'b1;
    end
  end

  a_r9_sof_period: assert property (@(posedge clk_rd_i) disable iff (!rst_ni)
    (rd_sof_o[0] && sof_seen_q) |-> (gap_q == HALF_AW'(HALF_DEPTH - 1)));

  a_r9_sof_aligned: assert property (@(posedge clk_rd_i) disable iff (!rst_ni)
    (rd_sof_o == '0) || (rd_sof_o == '1));

  a_r6_no_write_idle: assert property (@(posedge clk_wr_i) disable iff (!rst_ni)
    !wr_valid_i |-> (chan_we == '0));

  a_r5_one_channel: assert property (@(posedge clk_wr_i) disable iff (!rst_ni)
    $onehot0(chan_we));

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    a_r7_underrun_not_valid: assert property (@(posedge clk_rd_i) disable iff (!rst_ni)
      underrun_o[g] |-> !rd_valid_o[g]);

    a_r7_zero_when_invalid: assert property (@(posedge clk_rd_i) disable iff (!rst_ni)
      !rd_valid_o[g] |-> (rd_data_o[g*SYM_W +: SYM_W] == '0));

    a_r8_flags_change_at_sof: assert property (@(posedge clk_rd_i) disable iff (!rst_ni)
      !rd_sof_o[g] |-> ($stable(rd_valid_o[g]) && $stable(underrun_o[g])));
  end
endmodule

bind sym_pingpong_buf sym_pingpong_buf_chk #(
  .N_CH(N_CH), .SYM_W(SYM_W), .HALF_DEPTH(HALF_DEPTH)
) u_chk (
  .clk_wr_i   (clk_wr_i),
  .clk_rd_i   (clk_rd_i),
  .rst_ni     (rst_ni),
  .wr_valid_i (wr_valid_i),
  .chan_we    (chan_we),
  .rd_data_o  (rd_data_o),
  .rd_valid_o (rd_valid_o),
  .rd_sof_o   (rd_sof_o),
  .underrun_o (underrun_o)
);

// File: tb/sym_pingpong_buf_test.sv
`timescale 1ns/1ps
module sym_pingpong_buf_test;
  localparam int N_CH = 2;
  localparam int SW   = 16;
  localparam int HD   = 256;
  localparam int M_IDLE = 0, M_DATA = 1, M_UND = 2;

  logic clk_wr = 1'b0, clk_rd = 1'b0, rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [0:0] wr_ch = '0;
  logic [SW-1:0] wr_data = '0;
  logic [N_CH*SW-1:0] rd_data;
  logic [N_CH-1:0] rd_valid, rd_sof, underrun;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5  clk_wr = ~clk_wr;
  always #20 clk_rd = ~clk_rd;

  sym_pingpong_buf #(.N_CH(N_CH), .SYM_W(SW), .HALF_DEPTH(HD)) uut (
    .clk_wr_i(clk_wr), .clk_rd_i(clk_rd), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_ch_i(wr_ch), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .rd_sof_o(rd_sof),
    .underrun_o(underrun)
  );

  function automatic logic [SW-1:0] pat(input int ch, input int blk, input int i);
    return {4'(ch), 4'(blk), 8'(i)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_sof();
    forever begin
      @(negedge clk_rd);
      if (rd_sof[0]) break;
    end
  endtask

  task automatic write_burst(input int ch, input int blk);
    for (int i = 0; i < HD; i++) begin
      @(negedge clk_wr);
      wr_valid = 1'b1; wr_ch = 1'(ch); wr_data = pat(ch, blk, i);
    end
    @(negedge clk_wr);
    wr_valid = 1'b0;
  endtask

  // two channels symbol by symbol, with an invalid filler cycle carrying junk
  task automatic write_interleaved(input int blk0, input int blk1);
    for (int i = 0; i < HD; i++) begin
      @(negedge clk_wr); wr_valid = 1'b1; wr_ch = 1'b0; wr_data = pat(0, blk0, i);
      @(negedge clk_wr); wr_valid = 1'b1; wr_ch = 1'b1; wr_data = pat(1, blk1, i);
      @(negedge clk_wr); wr_valid = 1'b0; wr_ch = 1'b0; wr_data = 16'hDEAD;
    end
    @(negedge clk_wr);
    wr_valid = 1'b0;
  endtask

  // one read half; one check per channel plus one on the start marker
  task automatic check_half(input int m0, input int b0, input int m1, input int b1, input string tag);
    int mode [N_CH];
    int blk  [N_CH];
    int bad  [N_CH];
    logic [63:0] fa [N_CH];
    logic [63:0] fe [N_CH];
    int sof_bad = 0;
    mode[0] = m0; mode[1] = m1; blk[0] = b0; blk[1] = b1;
    for (int c = 0; c < N_CH; c++) begin bad[c] = 0; fa[c] = 0; fe[c] = 0; end
    wait_sof();
    for (int i = 0; i < HD; i++) begin
      if (i > 0) @(negedge clk_rd);
      if (rd_sof != ((i == 0) ? 2'b11 : 2'b00)) sof_bad++;
      for (int c = 0; c < N_CH; c++) begin
        logic [SW-1:0] ed;
        logic ev, eu;
        ed = (mode[c] == M_DATA) ? pat(c, blk[c], i) : '0;
        ev = (mode[c] == M_DATA);
        eu = (mode[c] == M_UND);
        if (rd_data[c*SW +: SW] != ed || rd_valid[c] != ev || underrun[c] != eu) begin
          if (bad[c] == 0) begin
            fa[c] = {i[15:0], 14'd0, rd_valid[c], underrun[c], 16'd0, rd_data[c*SW +: SW]};
            fe[c] = {i[15:0], 14'd0, ev, eu, 16'd0, ed};
          end
          bad[c]++;
        end
      end
    end
    for (int c = 0; c < N_CH; c++)
      chk(bad[c] == 0, $sformatf("%s ch%0d (idx,valid,underrun,data)", tag, c), fa[c], fe[c]);
    chk(sof_bad == 0, {tag, " R9 start marker once per half"}, 64'(sof_bad), 0);
  endtask

  task automatic test_reset();
    #12;
    chk(rd_data == '0, "R1 reset data", 64'(rd_data), 0);
    chk(rd_valid == '0, "R1 reset valid", 64'(rd_valid), 0);
    chk(rd_sof == '0, "R1 reset sof", 64'(rd_sof), 0);
    chk(underrun == '0, "R1 reset underrun", 64'(underrun), 0);
    @(negedge clk_rd);
    rst_n = 1'b1;
  endtask

  // half A: nothing primed yet; ch0 gets its first half
  task automatic test_prime();
    fork
      check_half(M_IDLE, 0, M_IDLE, 0, "R2 idle before first half");
      begin wait_sof(); write_burst(0, 1); end
    join
  endtask

  // half B: ch0 first block out; interleaved writes of ch0 blk2 and ch1 blk1
  task automatic test_interleave();
    fork
      check_half(M_DATA, 1, M_IDLE, 0, "R3 R5 first half ch0, ch1 untouched");
      begin wait_sof(); write_interleaved(2, 1); end
    join
  endtask

  // half C: ch0 second block from other half, ch1 first block; gaps ignored
  task automatic test_alternate();
    check_half(M_DATA, 2, M_DATA, 1, "R4 R5 R6 alternate half and interleave");
  endtask

  // half D: both underrun; ch0 half completes mid-way and must not show yet
  task automatic test_underrun_midfill();
    fork
      check_half(M_UND, 0, M_UND, 0, "R7 R8 underrun with mid-half completion");
      begin wait_sof(); repeat (100) @(negedge clk_rd); write_burst(0, 3); end
    join
  endtask

  // half E: ch0 picks up the mid-half block at the boundary, ch1 still starved
  task automatic test_recover();
    check_half(M_DATA, 3, M_UND, 0, "R8 R4 R7 switch at boundary only");
  endtask

  initial begin
    test_reset();
    test_prime();
    test_interleave();
    test_alternate();
    test_underrun_midfill();
    test_recover();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule